// File: doc/BRIEF.md
# Bus-Attached Accumulator Adder/Subtractor

This block is the arithmetic slice of a small bus-based datapath. It holds two 8-bit registers. The accumulator register is the left operand and the operand register is the right operand. Both load from one shared data bus and can each place their value back on that bus. A single ripple adder chain forms either the sum or the difference of the two registers. The result reaches the bus only while the sum output strobe is high. A two-bit flag register samples the final carry of the chain and a result-is-zero indication, and it does so only when told to.

All control strobes are set up while the clock is low, and every register changes on the rising edge. The bus is a multiplexer, not a tri-state net, and it reads zero when nothing drives it. The source that drives it is one of five selections:

- idle (nothing drives, bus is zero)
- external (a value supplied from outside the block)
- accumulator
- operand
- sum

Subtraction feeds the inverted operand into the same chain with a carry-in of one. The carry flag therefore reads one exactly when the accumulator is greater than or equal to the operand.

Top module: `bus_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator, the operand register and both flags are cleared to zero on that edge.
- R2: The accumulator takes the value of `bus_data` at a rising edge when `acc_load` is high, and keeps its value at every other edge.
- R3: The operand register takes the value of `bus_data` at a rising edge when `opd_load` is high, and keeps its value at every other edge.
- R4: With `sub_mode` low and `sum_drive` high, `bus_data` equals (accumulator + operand) mod 256.
- R5: With `sub_mode` high and `sum_drive` high, `bus_data` equals (accumulator − operand) mod 256, formed as accumulator + inverted operand + 1.
- R6: At a rising edge with `flag_load` high, `flag_carry` takes the carry out of bit 7 of the adder chain. When adding, this is 1 when the true sum exceeds 255. When subtracting, it is 1 when the accumulator is greater than or equal to the operand.
- R7: At a rising edge with `flag_load` high, `flag_zero` becomes 1 exactly when the 8-bit adder result is 0x00.
- R8: At a rising edge with `flag_load` low and `rst` low, both flags keep their values, even though the registers and the adder result change.
- R9: `bus_data` reads 0x00 when no drive strobe is high. With exactly one of `ext_drive`, `acc_drive` or `opd_drive` high, it carries `ext_data`, the accumulator or the operand register respectively.
- R10: While `sum_drive` is low, the adder result never appears on `bus_data`, whatever the values of the registers and `sub_mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ext_drive | input | 1 | Places `ext_data` on the bus |
| ext_data | input | 8 | Value offered by an outside bus source |
| acc_load | input | 1 | Loads the accumulator from the bus |
| acc_drive | input | 1 | Places the accumulator on the bus |
| opd_load | input | 1 | Loads the operand register from the bus |
| opd_drive | input | 1 | Places the operand register on the bus |
| sub_mode | input | 1 | 1 selects subtract, 0 selects add |
| sum_drive | input | 1 | Places the adder result on the bus |
| flag_load | input | 1 | Loads both flags from the adder |
| bus_data | output | 8 | Shared bus value (0x00 when idle) |
| flag_carry | output | 1 | Registered final carry of the adder chain |
| flag_zero | output | 1 | Registered zero-result indication |

## Verification
The assertions assume that at most one of the four drive strobes is high in any cycle. The bus encoder does have a fixed priority, but a correct system never relies on it, so the assertions treat two drivers at once as a fault in the surroundings. The stimulus keeps to this by raising exactly one drive strobe per step: the external source while loading a register, a single register strobe while reading it back, or the sum strobe while capturing flags. The sweep covers sixteen evenly spread values for each register, including 0x00, 0xFF and equal pairs, in both modes.

// File: rtl/bus_alu_pkg.sv
package bus_alu_pkg;

    // Who currently owns the shared bus.
    typedef enum logic [2:0] {
        SRC_IDLE = 3'd0,
        SRC_EXT  = 3'd1,
        SRC_ACC  = 3'd2,
        SRC_OPD  = 3'd3,
        SRC_SUM  = 3'd4
    } bus_src_e;

    // Populated flag slots.
    typedef struct packed {
        logic carry;
        logic zero;
    } alu_flags_t;

endpackage

// File: rtl/bus_word_reg.sv
module bus_word_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/bus_addsub.sv
module bus_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         sub,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         is_zero
);

    logic [W:0]   chain;
    logic [W-1:0] rhs_eff;

    // Subtract: invert the right operand and inject a carry of one.
    assign rhs_eff  = rhs ^ {W{sub}};
    assign chain[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign result[i]  = lhs[i] ^ rhs_eff[i] ^ chain[i];
        assign chain[i+1] = (lhs[i] & rhs_eff[i]) | (chain[i] & (lhs[i] ^ rhs_eff[i]));
    end

    assign carry_out = chain[W];
    assign is_zero   = ~|result;

endmodule

// File: rtl/bus_flag_reg.sv
module bus_flag_reg
    import bus_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  alu_flags_t next_flags,
    output alu_flags_t flags
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (load) begin
            flags <= next_flags;
        end
    end

endmodule

// File: rtl/bus_source_mux.sv
module bus_source_mux
    import bus_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         ext_en,
    input  logic         acc_en,
    input  logic         opd_en,
    input  logic         sum_en,
    input  logic [W-1:0] ext_val,
    input  logic [W-1:0] acc_val,
    input  logic [W-1:0] opd_val,
    input  logic [W-1:0] sum_val,
    output logic [W-1:0] bus
);

    bus_src_e src;

    // Fixed priority only matters when the one-driver rule is broken.
    always_comb begin
        if (sum_en) begin
            src = SRC_SUM;
        end else if (acc_en) begin
            src = SRC_ACC;
        end else if (opd_en) begin
            src = SRC_OPD;
        end else if (ext_en) begin
            src = SRC_EXT;
        end else begin
            src = SRC_IDLE;
        end
    end

    always_comb begin
        unique case (src)
            SRC_SUM: bus = sum_val;
            SRC_ACC: bus = acc_val;
            SRC_OPD: bus = opd_val;
            SRC_EXT: bus = ext_val;
            default: bus = '0;
        endcase
    end

endmodule

// File: rtl/bus_alu.sv
module bus_alu
    import bus_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ext_drive,
    input  logic [W-1:0] ext_data,
    input  logic         acc_load,
    input  logic         acc_drive,
    input  logic         opd_load,
    input  logic         opd_drive,
    input  logic         sub_mode,
    input  logic         sum_drive,
    input  logic         flag_load,
    output logic [W-1:0] bus_data,
    output logic         flag_carry,
    output logic         flag_zero
);

    logic [W-1:0] acc_q;
    logic [W-1:0] opd_q;
    logic [W-1:0] sum_val;
    logic         sum_carry;
    logic         sum_zero;
    alu_flags_t   flags_d;
    alu_flags_t   flags_q;

    bus_word_reg #(.W(W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .load (acc_load),
        .d    (bus_data),
        .q    (acc_q)
    );

    bus_word_reg #(.W(W)) u_opd (
        .clk  (clk),
        .rst  (rst),
        .load (opd_load),
        .d    (bus_data),
        .q    (opd_q)
    );

    bus_addsub #(.W(W)) u_addsub (
        .lhs       (acc_q),
        .rhs       (opd_q),
        .sub       (sub_mode),
        .result    (sum_val),
        .carry_out (sum_carry),
        .is_zero   (sum_zero)
    );

    assign flags_d.carry = sum_carry;
    assign flags_d.zero  = sum_zero;

    bus_flag_reg u_flags (
        .clk        (clk),
        .rst        (rst),
        .load       (flag_load),
        .next_flags (flags_d),
        .flags      (flags_q)
    );

    bus_source_mux #(.W(W)) u_mux (
        .ext_en  (ext_drive),
        .acc_en  (acc_drive),
        .opd_en  (opd_drive),
        .sum_en  (sum_drive),
        .ext_val (ext_data),
        .acc_val (acc_q),
        .opd_val (opd_q),
        .sum_val (sum_val),
        .bus     (bus_data)
    );

    assign flag_carry = flags_q.carry;
    assign flag_zero  = flags_q.zero;

endmodule

// File: rtl/bus_alu_chk.sv
module bus_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         ext_drive,
    input logic [W-1:0] ext_data,
    input logic         acc_load,
    input logic         acc_drive,
    input logic         opd_load,
    input logic         opd_drive,
    input logic         sub_mode,
    input logic         sum_drive,
    input logic         flag_load,
    input logic [W-1:0] bus_data,
    input logic         flag_carry,
    input logic         flag_zero
);

    // Environment rule: never two bus drivers at once (R9).
    p_single_driver_r9: assert property (@(posedge clk) disable iff (rst)
        $countones({ext_drive, acc_drive, opd_drive, sum_drive}) <= 1);

    p_idle_bus_r9: assert property (@(posedge clk) disable iff (rst)
        !(ext_drive || acc_drive || opd_drive || sum_drive) |-> bus_data == '0);

    p_ext_passes_r9: assert property (@(posedge clk) disable iff (rst)
        (ext_drive && !acc_drive && !opd_drive && !sum_drive) |-> bus_data == ext_data);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!flag_carry && !flag_zero));

    p_flags_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!flag_load && !rst) |=> ($stable(flag_carry) && $stable(flag_zero)));

    p_zero_tracks_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_load && sum_drive) |=> (flag_zero == ($past(bus_data) == '0)));

    p_acc_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_load && !acc_drive) ##1 (acc_drive && !sum_drive) |-> bus_data == $past(bus_data));

    p_opd_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (opd_load && !opd_drive) ##1 (opd_drive && !sum_drive && !acc_drive) |-> bus_data == $past(bus_data));

endmodule

bind bus_alu bus_alu_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ext_drive  (ext_drive),
    .ext_data   (ext_data),
    .acc_load   (acc_load),
    .acc_drive  (acc_drive),
    .opd_load   (opd_load),
    .opd_drive  (opd_drive),
    .sub_mode   (sub_mode),
    .sum_drive  (sum_drive),
    .flag_load  (flag_load),
    .bus_data   (bus_data),
    .flag_carry (flag_carry),
    .flag_zero  (flag_zero)
);

// File: tb/tb_bus_alu.sv
`timescale 1ns/1ps
module tb_bus_alu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_drive = 1'b0;
    logic [7:0] ext_data = '0;
    logic       acc_load = 1'b0;
    logic       acc_drive = 1'b0;
    logic       opd_load = 1'b0;
    logic       opd_drive = 1'b0;
    logic       sub_mode = 1'b0;
    logic       sum_drive = 1'b0;
    logic       flag_load = 1'b0;
    logic [7:0] bus_data;
    logic       flag_carry;
    logic       flag_zero;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    bus_alu #(.W(8)) dut (
        .clk        (clk),
        .rst        (rst),
        .ext_drive  (ext_drive),
        .ext_data   (ext_data),
        .acc_load   (acc_load),
        .acc_drive  (acc_drive),
        .opd_load   (opd_load),
        .opd_drive  (opd_drive),
        .sub_mode   (sub_mode),
        .sum_drive  (sum_drive),
        .flag_load  (flag_load),
        .bus_data   (bus_data),
        .flag_carry (flag_carry),
        .flag_zero  (flag_zero)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_ctl;
        ext_drive = 1'b0; acc_load = 1'b0; acc_drive = 1'b0;
        opd_load  = 1'b0; opd_drive = 1'b0; sum_drive = 1'b0; flag_load = 1'b0;
    endtask

    task automatic load_reg(input bit to_opd, input logic [7:0] v);
        ext_drive = 1'b1; ext_data = v;
        acc_load = !to_opd; opd_load = to_opd;
        cyc();
        idle_ctl();
    endtask

    task automatic peek(input bit from_opd, output logic [7:0] v);
        acc_drive = !from_opd; opd_drive = from_opd;
        #1 v = bus_data;
        acc_drive = 1'b0; opd_drive = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        @(negedge clk); cyc(); cyc();
        // R1: reset state
        check("R1 carry after reset", int'(flag_carry), 0);
        check("R1 zero after reset", int'(flag_zero), 0);
        peek(1'b0, v); check("R1 accumulator after reset", int'(v), 0);
        peek(1'b1, v); check("R1 operand after reset", int'(v), 0);
        rst = 1'b0;
        #1 check("R9 idle bus reads zero", int'(bus_data), 0);
        ext_drive = 1'b1; ext_data = 8'h5A;
        #1 check("R9 external value on bus", int'(bus_data), 'h5A);
        idle_ctl();

        // R2 / R3: load and hold
        load_reg(1'b0, 8'hC3);
        load_reg(1'b1, 8'h3C);
        peek(1'b0, v); check("R2 accumulator load", int'(v), 'hC3);
        peek(1'b1, v); check("R3 operand load", int'(v), 'h3C);
        ext_drive = 1'b1; ext_data = 8'h99; cyc(); idle_ctl();
        peek(1'b0, v); check("R2 accumulator holds without load", int'(v), 'hC3);
        peek(1'b1, v); check("R3 operand holds without load", int'(v), 'h3C);

        // R10: sum hidden while its strobe is low
        sub_mode = 1'b0;
        #1 check("R10 add result not on bus", int'(bus_data), 0);
        sub_mode = 1'b1;
        #1 check("R10 sub result not on bus", int'(bus_data), 0);

        // Sweep: R4 R5 R6 R7
        for (int op = 0; op < 2; op++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    int a;
                    int b;
                    int full;
                    int res;
                    int cy;
                    a = i * 17;
                    b = j * 17;
                    load_reg(1'b0, 8'(a));
                    load_reg(1'b1, 8'(b));
                    if (op == 0) begin
                        full = a + b;
                        res  = full % 256;
                        cy   = (full > 255) ? 1 : 0;
                    end else begin
                        res  = (a - b + 256) % 256;
                        cy   = (a >= b) ? 1 : 0;
                    end
                    sub_mode = (op == 1);
                    sum_drive = 1'b1; flag_load = 1'b1;
                    #1;
                    if (op == 0) check("R4 sum on bus", int'(bus_data), res);
                    else         check("R5 difference on bus", int'(bus_data), res);
                    cyc();
                    idle_ctl();
                    check("R6 carry flag", int'(flag_carry), cy);
                    check("R7 zero flag", int'(flag_zero), (res == 0) ? 1 : 0);
                end
            end
        end

        // R8: flags hold when not loaded. Last sweep: 255-255 -> carry 1, zero 1.
        sub_mode = 1'b0;
        load_reg(1'b0, 8'h01);
        load_reg(1'b1, 8'h02);
        cyc();
        check("R8 carry held", int'(flag_carry), 1);
        check("R8 zero held", int'(flag_zero), 1);

        // R1: mid-run reset
        load_reg(1'b0, 8'h77);
        rst = 1'b1; cyc(); rst = 1'b0;
        check("R1 carry cleared by reset", int'(flag_carry), 0);
        check("R1 zero cleared by reset", int'(flag_zero), 0);
        peek(1'b0, v); check("R1 accumulator cleared by reset", int'(v), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule